// File: doc/BRIEF.md
# Table Access Mailbox Responder

This block answers table-read requests arriving over a data-object mailbox pair. Software writes a three-dword request object into the write mailbox and pulses `go`. The block then validates the request. If the request is acceptable, the block assembles a response object in the read mailbox. The response is a three-dword response structure followed by the payload of one entry from a fixed, read-only attribute table of six variable-length entries.

The response also names the handle of the following entry. Software can therefore walk the table by feeding each returned handle back as the next request. After the final entry, the returned handle is all ones. Software drains the read mailbox one dword per `rd_en` strobe.

A request is silently discarded, with no response and no change to the mailbox length, in three cases:
- its length field is too short;
- its handle is out of range;
- the read mailbox lacks room for the whole response.

Top module: `tam_responder`

## Requirements
- R1: After reset, `rd_valid` is 0, `rd_len` is 0 and `busy` is 0.
- R2: A request whose length field (write dword 1, all 32 bits, in dwords) is below 3 is discarded: `busy` stays low, and `rd_len` and the read mailbox are unchanged.
- R3: A request whose handle (write dword 2, bits [31:16]) is 6 or more is discarded in the same way.
- R4: Response dword 0 is {8'h00 reserved, 8'h02 table-access object type, VENDOR_ID[15:0]} (bits [31:24], [23:16], [15:0]).
- R5: Response dword 1 holds the response length in dwords, ceil((12 + entry bytes) / 4). Entry sizes are 20 bytes for handle 0, 14 bytes for handles 1 to 4, and 16 bytes for handle 5, giving lengths of 8, 7 and 7.
- R6: Response dword 2 holds the response code 8'h00 in bits [7:0] and the table identifier 8'h00 in bits [15:8].
- R7: Response dword 2 bits [31:16] hold the next handle: the requested handle + 1, or 16'hFFFF when handle 5 (the last entry) was requested.
- R8: The entry payload starts at response dword 3. Every entry header dword is {bytes[15:0], 8'h00, kind}, with kind 0 for affinity, 1 for latency/bandwidth and 2 for memory type. The dwords that follow the header depend on the handle:
  - Handle 0 (affinity): {16'h0, 8'h04 non-volatile flag, 8'h00 region id}, then MEM_BYTES low, MEM_BYTES high, then 0.
  - Handles 1 to 4 (latency/bandwidth): {16'h0, data type = handle-1, 8'h00}, then the unit, then {16'h0, value}. Handle 1 is read latency (unit 10000, value 15). Handle 2 is write latency (unit 10000, value 25). Handle 3 is read bandwidth (unit 1000, value 16). Handle 4 is write bandwidth (unit 1000, value 16).
  - Handle 5 (memory type): {16'h0, 8'h02, 8'h00}, then MEM_BYTES low, then MEM_BYTES high.
- R9: `rd_len` rises by the response length in the cycle the last response dword is written. Responses queue back to back in request order.
- R10: Each `rd_en` cycle with `rd_valid` high removes one dword and lowers `rd_len` by one. `rd_valid` is high exactly when `rd_len` is nonzero. `rd_en` with an empty mailbox has no effect.
- R11: A request whose response exceeds the free space of the read mailbox (RD_DEPTH dwords in total) is discarded.
- R12: A `go` pulse while `busy` is high is ignored, and the response being built is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Writes one request dword into the write mailbox |
| wr_data | input | 32 | Request dword |
| go | input | 1 | Submits the request and rewinds the write mailbox |
| rd_en | input | 1 | Removes one dword from the read mailbox |
| rd_data | output | 32 | Dword at the head of the read mailbox |
| rd_valid | output | 1 | Response data is available |
| rd_len | output | $clog2(RD_DEPTH)+1 | Dwords of completed responses awaiting read |
| busy | output | 1 | A response is being assembled |

## Verification
The bench walks every handle and compares every response dword against an independently built expectation. This catches a wrong length rounding for the 14-byte entries, a next-handle that wraps to 6 instead of all ones, or a payload shifted by one dword.

Length 2 and handle 6 are each submitted alone. A design that accepted them would raise `rd_len` or `busy`.

The mailbox is filled to exactly its depth and then offered one more request. A design without a room check would overwrite unread dwords, and the drain would return wrong data.

A second `go` is sent mid-build. A design that restarted would return the wrong entry.

// File: rtl/tam_pkg.sv
package tam_pkg;
  localparam int unsigned REQ_BYTES   = 12;
  localparam int unsigned RSP_BYTES   = 12;
  localparam int unsigned RSP_HDR_DW  = (RSP_BYTES + 3) / 4;
  localparam int unsigned ENTRY_COUNT = 6;

  localparam logic [7:0]  OBJ_TYPE_TABLE = 8'h02;
  localparam logic [7:0]  RSP_CODE_READ  = 8'h00;
  localparam logic [7:0]  TABLE_ID_ATTR  = 8'h00;
  localparam logic [15:0] HANDLE_END     = 16'hFFFF;

  typedef enum logic [7:0] {
    KIND_AFFINITY = 8'h00,
    KIND_LATBW    = 8'h01,
    KIND_MEMTYPE  = 8'h02
  } kind_e;

  typedef enum logic {ST_IDLE, ST_BUILD} state_e;

  // payload size of each table entry in bytes
  function automatic logic [15:0] entry_bytes(input logic [15:0] h);
    if (h == 16'd0)      return 16'd20;
    else if (h == 16'd5) return 16'd16;
    else                 return 16'd14;
  endfunction

  function automatic logic [15:0] dw_round(input logic [15:0] nbytes);
    return (nbytes + 16'd3) >> 2;
  endfunction

  function automatic logic [15:0] next_handle(input logic [15:0] h);
    return (h == 16'(ENTRY_COUNT - 1)) ? HANDLE_END : h + 16'd1;
  endfunction
endpackage

// File: rtl/tam_entry_rom.sv
module tam_entry_rom #(
  parameter logic [63:0] MEM_BYTES = 64'h1000_0000,
  parameter logic [7:0]  REGION_ID = 8'h00
) (
  input  logic [2:0]  idx,
  input  logic [2:0]  word,
  output logic [31:0] data
);
  import tam_pkg::*;

  localparam logic [31:0] LAT_UNIT = 32'd10000;
  localparam logic [31:0] BW_UNIT  = 32'd1000;

  logic [7:0]  dtype;
  logic [15:0] perf;
  logic [31:0] unit;

  always_comb begin
    dtype = 8'(idx) - 8'd1;
    unit  = (idx < 3'd3) ? LAT_UNIT : BW_UNIT;
    case (idx)
      3'd1:    perf = 16'd15;
      3'd2:    perf = 16'd25;
      default: perf = 16'd16;
    endcase
    data = '0;
    case (idx)
      3'd0: begin
        case (word)
          3'd0:    data = {entry_bytes(16'd0), 8'h00, KIND_AFFINITY};
          3'd1:    data = {16'h0, 8'h04, REGION_ID};
          3'd2:    data = MEM_BYTES[31:0];
          3'd3:    data = MEM_BYTES[63:32];
          default: data = '0;
        endcase
      end
      3'd5: begin
        case (word)
          3'd0:    data = {entry_bytes(16'd5), 8'h00, KIND_MEMTYPE};
          3'd1:    data = {16'h0, 8'h02, REGION_ID};
          3'd2:    data = MEM_BYTES[31:0];
          3'd3:    data = MEM_BYTES[63:32];
          default: data = '0;
        endcase
      end
      default: begin
        case (word)
          3'd0:    data = {entry_bytes(16'd1), 8'h00, KIND_LATBW};
          3'd1:    data = {16'h0, dtype, REGION_ID};
          3'd2:    data = unit;
          3'd3:    data = {16'h0, perf};
          default: data = '0;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/tam_req_check.sv
module tam_req_check #(
  parameter int CNT_W = 5
) (
  input  logic             go,
  input  logic             busy,
  input  logic [31:0]      req_len_dw,
  input  logic [15:0]      req_handle,
  input  logic [CNT_W-1:0] room,
  output logic             accept,
  output logic             drop,
  output logic [CNT_W-1:0] rsp_len
);
  import tam_pkg::*;

  localparam logic [31:0] MIN_DW = 32'((REQ_BYTES + 3) / 4);

  logic len_ok, handle_ok, fits, ok;

  always_comb begin
    rsp_len   = CNT_W'(dw_round(16'(RSP_BYTES) + entry_bytes(req_handle)));
    len_ok    = req_len_dw >= MIN_DW;
    handle_ok = req_handle < 16'(ENTRY_COUNT);
    fits      = rsp_len <= room;
    ok        = len_ok && handle_ok && fits;
    accept    = go && !busy && ok;
    drop      = go && !busy && !ok;
  end
endmodule

// File: rtl/tam_rd_fifo.sv
module tam_rd_fifo #(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [31:0]      push_data,
  input  logic             pop_req,
  input  logic             commit,
  input  logic [CNT_W-1:0] commit_len,
  output logic [31:0]      head,
  output logic [CNT_W-1:0] vis_len,
  output logic [CNT_W-1:0] room
);
  logic [31:0]      mem [DEPTH];
  logic [CNT_W-1:0] wptr, rptr, occ;
  logic             pop_fire;

  assign occ      = wptr - rptr;
  assign room     = CNT_W'(DEPTH) - occ;
  assign pop_fire = pop_req && (vis_len != '0);
  assign head     = mem[rptr[PTR_W-1:0]];

  always_ff @(posedge clk) begin
    if (push) mem[wptr[PTR_W-1:0]] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      vis_len <= '0;
    end else begin
      if (push)     wptr <= wptr + 1'b1;
      if (pop_fire) rptr <= rptr + 1'b1;
      vis_len <= vis_len + (commit ? commit_len : '0) - (pop_fire ? CNT_W'(1) : '0);
    end
  end

  // R9
  vis_len_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !pop_fire |=> vis_len == $past(vis_len) + $past(commit_len));
  // R10
  vis_len_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire && !commit |=> vis_len == $past(vis_len) - 1'b1);
  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CNT_W'(DEPTH));
  // R10
  vis_within_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vis_len <= occ);
endmodule

// File: rtl/tam_responder.sv
module tam_responder #(
  parameter logic [15:0] VENDOR_ID = 16'h0C5A,
  parameter int          RD_DEPTH  = 16,
  parameter logic [63:0] MEM_BYTES = 64'h1000_0000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [31:0]                wr_data,
  input  logic                       go,
  input  logic                       rd_en,
  output logic [31:0]                rd_data,
  output logic                       rd_valid,
  output logic [$clog2(RD_DEPTH):0]  rd_len,
  output logic                       busy
);
  import tam_pkg::*;

  localparam int CNT_W = $clog2(RD_DEPTH) + 1;

  // write mailbox: only length and handle are kept
  logic [1:0]  wr_ptr;
  logic [31:0] req_len_q;
  logic [15:0] req_handle_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr       <= '0;
      req_len_q    <= '0;
      req_handle_q <= '0;
    end else if (go) begin
      wr_ptr <= '0;
    end else if (wr_en && wr_ptr != 2'd3) begin
      if (wr_ptr == 2'd1) req_len_q    <= wr_data;
      if (wr_ptr == 2'd2) req_handle_q <= wr_data[31:16];
      wr_ptr <= wr_ptr + 2'd1;
    end
  end

  // request validation
  logic             accept, drop;
  logic [CNT_W-1:0] rsp_len, room;
  state_e           state;

  tam_req_check #(.CNT_W(CNT_W)) u_check (
    .go(go), .busy(busy), .req_len_dw(req_len_q), .req_handle(req_handle_q),
    .room(room), .accept(accept), .drop(drop), .rsp_len(rsp_len)
  );

  // response builder
  logic [15:0]      handle_q;
  logic [CNT_W-1:0] len_q, word_q;
  logic             push, finish;
  logic [31:0]      push_data, rom_data;

  assign busy   = (state == ST_BUILD);
  assign push   = busy;
  assign finish = push && (word_q == len_q - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      handle_q <= '0;
      len_q    <= '0;
      word_q   <= '0;
    end else if (state == ST_IDLE) begin
      if (accept) begin
        state    <= ST_BUILD;
        handle_q <= req_handle_q;
        len_q    <= rsp_len;
        word_q   <= '0;
      end
    end else begin
      word_q <= word_q + 1'b1;
      if (finish) state <= ST_IDLE;
    end
  end

  tam_entry_rom #(.MEM_BYTES(MEM_BYTES)) u_rom (
    .idx(handle_q[2:0]), .word(3'(word_q - CNT_W'(RSP_HDR_DW))), .data(rom_data)
  );

  always_comb begin
    case (word_q)
      CNT_W'(0): push_data = {8'h00, OBJ_TYPE_TABLE, VENDOR_ID};
      CNT_W'(1): push_data = 32'(len_q);
      CNT_W'(2): push_data = {next_handle(handle_q), TABLE_ID_ATTR, RSP_CODE_READ};
      default:   push_data = rom_data;
    endcase
  end

  tam_rd_fifo #(.DEPTH(RD_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
    .pop_req(rd_en), .commit(finish), .commit_len(len_q),
    .head(rd_data), .vis_len(rd_len), .room(room)
  );

  assign rd_valid = (rd_len != '0);

  // R2 R3
  drop_stays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> !busy);
  // R12
  busy_go_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go && busy |=> $stable(handle_q) && $stable(len_q));
  // R5
  len_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (len_q >= CNT_W'(7)) && (len_q <= CNT_W'(8)));
endmodule

// File: tb/tam_responder_tb.sv
module tam_responder_tb;
  localparam logic [15:0] VID = 16'h0C5A;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, go = 1'b0, rd_en = 1'b0;
  logic [31:0] wr_data = '0;
  wire  [31:0] rd_data;
  wire         rd_valid, busy;
  wire  [4:0]  rd_len;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  tam_responder u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .go(go),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .rd_len(rd_len), .busy(busy)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push_w(input logic [31:0] w, input string tag);
    exp_q.push_back(w);
    tag_q.push_back(tag);
  endtask

  // scoreboard driver side: expected response for handle h
  task automatic expect_rsp(input int h);
    int nb = (h == 0) ? 20 : ((h == 5) ? 16 : 14);
    push_w({8'h00, 8'h02, VID}, "R4 header");
    push_w(32'((12 + nb + 3) / 4), "R5 length");
    push_w({(h == 5) ? 16'hFFFF : 16'(h + 1), 8'h00, 8'h00}, "R6 R7 code/next");
    push_w({16'(nb), 8'h00, 8'((h == 0) ? 0 : ((h == 5) ? 2 : 1))}, "R8 entry header");
    if (h == 0) begin
      push_w(32'h0000_0400, "R8 affinity flags");
      push_w(32'h1000_0000, "R8 affinity size lo");
      push_w(32'h0, "R8 affinity size hi");
      push_w(32'h0, "R8 affinity base");
    end else if (h == 5) begin
      push_w(32'h0000_0200, "R8 memtype attr");
      push_w(32'h1000_0000, "R8 memtype size lo");
      push_w(32'h0, "R8 memtype size hi");
    end else begin
      push_w({16'h0, 8'(h - 1), 8'h00}, "R8 latbw type");
      push_w((h <= 2) ? 32'd10000 : 32'd1000, "R8 latbw unit");
      push_w((h == 1) ? 32'd15 : ((h == 2) ? 32'd25 : 32'd16), "R8 latbw value");
    end
  endtask

  // scoreboard monitor side
  always @(negedge clk) begin
    if (rd_en && rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R10 unexpected word actual=%h expected=none", rd_data);
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  task automatic send(input logic [31:0] len, input logic [15:0] h);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_data = {8'h00, 8'h02, VID};
    @(posedge clk); #1; wr_data = len;
    @(posedge clk); #1; wr_data = {h, 8'h00, 8'h00};
    @(posedge clk); #1; wr_en = 1'b0; go = 1'b1;
    @(posedge clk); #1; go = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic drain();
    @(posedge clk); #1;
    while (rd_valid) begin
      rd_en = 1'b1;
      @(posedge clk); #1;
    end
    rd_en = 1'b0;
    @(negedge clk);
    check("R10 valid clear", 32'(rd_valid), 32'd0);
    check("R10 len zero", 32'(rd_len), 32'd0);
    check("R10 all words seen", exp_q.size(), 32'd0);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 rd_valid", 32'(rd_valid), 32'd0);
    check("R1 rd_len", 32'(rd_len), 32'd0);
    check("R1 busy", 32'(busy), 32'd0);
    rst_n = 1'b1;

    // table walk, every handle (R5 R7 R8 R9)
    for (int h = 0; h < 6; h++) begin
      send((h == 2) ? 32'd3 : 32'd5, 16'(h));
      expect_rsp(h);
      wait_idle();
      check("R9 rd_len after response", 32'(rd_len), (h == 0) ? 32'd8 : 32'd7);
      drain();
    end

    // R2 short request
    send(32'd2, 16'd0);
    repeat (3) @(negedge clk);
    check("R2 busy", 32'(busy), 32'd0);
    check("R2 rd_len", 32'(rd_len), 32'd0);

    // R3 handle out of range
    send(32'd3, 16'd6);
    repeat (3) @(negedge clk);
    check("R3 handle 6 rd_len", 32'(rd_len), 32'd0);
    send(32'd3, 16'hFFFF);
    repeat (3) @(negedge clk);
    check("R3 handle FFFF busy", 32'(busy), 32'd0);
    check("R3 handle FFFF rd_len", 32'(rd_len), 32'd0);

    // R9 back-to-back queueing, in order
    send(32'd3, 16'd1); expect_rsp(1); wait_idle();
    send(32'd3, 16'd5); expect_rsp(5); wait_idle();
    check("R9 accumulated", 32'(rd_len), 32'd14);
    drain();

    // R11 fill to depth then overflow attempt
    send(32'd3, 16'd0); expect_rsp(0); wait_idle();
    send(32'd3, 16'd0); expect_rsp(0); wait_idle();
    check("R11 full", 32'(rd_len), 32'd16);
    send(32'd3, 16'd1);
    repeat (3) @(negedge clk);
    check("R11 dropped busy", 32'(busy), 32'd0);
    check("R11 dropped rd_len", 32'(rd_len), 32'd16);
    drain();

    // R12 go while busy
    send(32'd3, 16'd0); expect_rsp(0);
    send(32'd3, 16'd2);
    wait_idle();
    repeat (2) @(negedge clk);
    check("R12 only first response", 32'(rd_len), 32'd8);
    drain();

    // R10 read strobes on empty mailbox
    @(posedge clk); #1; rd_en = 1'b1;
    repeat (3) @(posedge clk);
    #1; rd_en = 1'b0;
    @(negedge clk);
    check("R10 empty read len", 32'(rd_len), 32'd0);
    send(32'd3, 16'd3); expect_rsp(3); wait_idle();
    drain();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule